// File: doc/BRIEF.md
# Internal Data RAM Window Mapper

This block steers every external-data-move access issued by a microcontroller core. An access either goes to a 1 KB on-chip data RAM or becomes a cycle on the external multiplexed address/data bus. The RAM occupies the top window of the 64 KB data space, addresses 0xFC00 to 0xFFFF. A two-bit control register decides where accesses inside that window go. Accesses below the window always go to the external bus.

Control bit 0 is the lock-out bit, `ram_off`. It comes out of reset at 1, and while it is 1 the window is served externally. Software can clear it but can never set it again: a write stores the old value ANDed with the written bit, and only reset restores 1. This means a stray write cannot silently disconnect the RAM once start-up code has enabled it. Control bit 1 is the trace bit, `trace_on`. It is an ordinary read/write bit that resets to 0. When it is set, internal RAM transfers are repeated on the external pins with the real address, the real data and the correct strobe, so that a bus analyser can observe them.

Each access is accepted in the cycle in which `req_valid` is high, because `req_ready` is always 1. The response (`resp_valid`, plus `resp_rdata` for reads) appears one clock later. Both the RAM port and the external bus are driven combinationally during the request cycle.

Top module: `xram_map_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 2'b01: bit 0 (`ram_off`) is 1 and bit 1 (`trace_on`) is 0.
- R2: While bit 0 is 1, an access to 0xFC00..0xFFFF keeps `ram_en` low and raises `ext_cycle`, with `ext_addr` equal to the request address.
- R3: While bit 0 is 0, an access to 0xFC00..0xFFFF raises `ram_en` with `ram_addr` = address minus 0xFC00, and `ram_we` follows `req_we`. A read returns the RAM's data.
- R4: Once bit 0 is 0, writing `cfg_wdata[0]`=1 leaves it at 0. Only reset returns it to 1.
- R5: Writing bit 0 as 0 when it is already 0 leaves it at 0 and has no other effect.
- R6: With bit 1 set, an internal access also raises `ext_cycle` and the matching strobe (`ext_rd` for reads, `ext_wr` for writes). `ext_addr` carries the request address. `ext_wdata` carries the write data on writes and the RAM read data on reads.
- R7: During a traced internal read, `resp_rdata` comes from `ram_rdata` and never from `ext_rdata`.
- R8: An access below 0xFC00 always raises `ext_cycle` and never `ram_en`, whatever the state of both bits.
- R9: Bit 1 is read/write: a write stores `cfg_wdata[1]`. It has no effect on accesses outside the window.
- R10: `req_ready` is always 1. `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. A read's `resp_rdata` comes from the selected target (RAM or external bus).
- R11: `cfg_rdata` always shows the current value of both control bits; a write is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Always 1: accepted in one cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | Access completed (one cycle after request) |
| resp_rdata | output | 8 | Read data of the completed access |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Bit 0 lock-out, bit 1 trace |
| cfg_rdata | output | 2 | Current control bits |
| ram_en | output | 1 | Internal RAM select |
| ram_we | output | 1 | Internal RAM write enable |
| ram_addr | output | 10 | Internal RAM word address |
| ram_wdata | output | 8 | Internal RAM write data |
| ram_rdata | input | 8 | Internal RAM read data (combinational) |
| ext_cycle | output | 1 | External bus cycle active |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | Data driven on external bus |
| ext_rdata | input | 8 | Data read from external bus |

## Verification
A wrong lock-out bit shows on the next window access: `ram_en` and `ext_cycle` swap. `cfg_rdata` also changes one cycle after the write that corrupted the bit. A lock-out bit that software can set again shows as a RAM disconnect right after a write of 1, so the bench follows every clear with such a write and then an internal access. A wrong trace bit or a wrong data-source mux shows in the same request cycle as a missing strobe or wrong `ext_wdata`. It also shows one cycle later as read data taken from the bus rather than from the RAM.

// File: rtl/xram_map_ctrl.sv
module xram_map_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ext_cycle,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata
);
  logic              ram_off, trace_on;
  logic [ADDR_W-1:0] off;
  logic              in_win, internal;

  assign off      = req_addr - WIN_BASE;
  assign in_win   = (req_addr >= WIN_BASE) && (off[ADDR_W-1:RAM_AW] == '0);
  assign internal = req_valid && in_win && !ram_off;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ram_off  <= 1'b1;
      trace_on <= 1'b0;
    end else if (cfg_we) begin
      ram_off  <= ram_off & cfg_wdata[0];
      trace_on <= cfg_wdata[1];
    end

  assign cfg_rdata = {trace_on, ram_off};
  assign req_ready = 1'b1;

  assign ram_en    = internal;
  assign ram_we    = internal && req_we;
  assign ram_addr  = off[RAM_AW-1:0];
  assign ram_wdata = req_wdata;

  assign ext_cycle = req_valid && (!internal || trace_on);
  assign ext_rd    = ext_cycle && !req_we;
  assign ext_wr    = ext_cycle && req_we;
  assign ext_addr  = req_addr;
  assign ext_wdata = (internal && !req_we) ? ram_rdata : req_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid && !req_we)
        resp_rdata <= internal ? ram_rdata : ext_rdata;
    end
endmodule

// File: rtl/xram_map_ctrl_chk.sv
module xram_map_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFC00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_rdata,
  input logic [1:0]        cfg_rdata,
  input logic              ram_en,
  input logic [DATA_W-1:0] ram_rdata,
  input logic              ext_cycle,
  input logic [ADDR_W-1:0] ext_addr
);
  logic above;
  assign above = req_addr >= WIN_BASE;

  assert_locked_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && above && cfg_rdata[0] |-> !ram_en && ext_cycle);

  assert_unlocked_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && above && !cfg_rdata[0] |-> ram_en);

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |=> !cfg_rdata[0]);

  assert_trace_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en && cfg_rdata[1] |-> ext_cycle && ext_addr == req_addr);

  assert_trace_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en && !req_we |=> resp_rdata == $past(ram_rdata));

  assert_low_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !above |-> ext_cycle && !ram_en);

  assert_resp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  always_comb if (rst_n) assert_ready_R10: assert (req_ready);
endmodule

bind xram_map_ctrl xram_map_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .resp_valid(resp_valid),
  .resp_rdata(resp_rdata), .cfg_rdata(cfg_rdata), .ram_en(ram_en),
  .ram_rdata(ram_rdata), .ext_cycle(ext_cycle), .ext_addr(ext_addr)
);

// File: tb/test_xram_map_ctrl.sv
`timescale 1ns/1ps
module test_xram_map_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic resp_valid;
  logic [7:0] resp_rdata;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0, cfg_rdata;
  logic ram_en, ram_we;
  logic [9:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic ext_cycle, ext_rd, ext_wr;
  logic [15:0] ext_addr;
  logic [7:0] ext_wdata, ext_rdata;

  int n_tests = 0, n_fail = 0;
  logic m_off = 1'b1, m_trace = 1'b0;
  logic [7:0] ram_mem [1024];
  logic [7:0] shadow [1024];

  always #10 clk = ~clk;

  xram_map_ctrl i_xram_map_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ext_cycle(ext_cycle), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  always_ff @(posedge clk) if (ram_en && ram_we) ram_mem[ram_addr] <= ram_wdata;
  assign ram_rdata = ram_mem[ram_addr];
  assign ext_rdata = ext_addr[7:0] ^ ext_addr[15:8] ^ 8'h5A;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_off = 1'b1; m_trace = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 2'b01, "R1 reset cfg", {30'd0, cfg_rdata}, 32'h1);
  endtask

  task automatic cfg_write(input logic [1:0] v, input string tag);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_off = m_off & v[0];
    m_trace = v[1];
    chk(cfg_rdata == {m_trace, m_off}, tag, {30'd0, cfg_rdata}, {30'd0, m_trace, m_off});
  endtask

  task automatic acc(input logic [15:0] a, input logic we, input logic [7:0] d);
    logic inw, intl, xc;
    logic [7:0] exp_rd;
    string tag;
    inw  = a >= 16'hFC00;
    intl = inw && !m_off;
    xc   = !intl || m_trace;
    exp_rd = intl ? shadow[a[9:0]] : (a[7:0] ^ a[15:8] ^ 8'h5A);
    tag = intl ? (m_trace ? "R6" : "R3") : (inw ? "R2" : (m_trace ? "R9" : "R8"));
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #2;
    chk(req_ready, "R10 ready", {31'd0, req_ready}, 32'd1);
    chk(ram_en == intl, tag, {31'd0, ram_en}, {31'd0, intl});
    chk(ext_cycle == xc, tag, {31'd0, ext_cycle}, {31'd0, xc});
    if (intl) begin
      chk(ram_addr == a[9:0] && ram_we == we, "R3 ram port", {21'd0, ram_we, ram_addr}, {21'd0, we, a[9:0]});
    end
    if (xc) begin
      chk(ext_addr == a && ext_rd == !we && ext_wr == we, tag,
          {14'd0, ext_rd, ext_wr, ext_addr}, {14'd0, !we, we, a});
      if (we) chk(ext_wdata == d, tag, {24'd0, ext_wdata}, {24'd0, d});
      else if (intl) chk(ext_wdata == exp_rd, "R6 read data on pins", {24'd0, ext_wdata}, {24'd0, exp_rd});
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid, "R10 resp", {31'd0, resp_valid}, 32'd1);
    if (!we) chk(resp_rdata == exp_rd, intl ? (m_trace ? "R7" : "R3") : "R10 ext data",
                 {24'd0, resp_rdata}, {24'd0, exp_rd});
    if (intl && we) shadow[a[9:0]] = d;
  endtask

  task automatic sweep(input logic [7:0] salt);
    for (int i = 0; i < 48; i++) begin
      logic [15:0] a;
      a = (i < 16) ? 16'hFBF8 + 16'(i) : (i < 32) ? 16'hFFF0 + 16'(i - 16) : 16'(i - 32) * 16'h0F31;
      acc(a, 1'b1, a[7:0] ^ salt);
      acc(a, 1'b0, 8'h00);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin ram_mem[i] = 8'h00; shadow[i] = 8'h00; end
    @(negedge clk);
    do_reset();
    @(negedge clk);
    chk(!resp_valid, "R10 idle", {31'd0, resp_valid}, 32'd0);
    sweep(8'h11);
    cfg_write(2'b11, "R9 trace set, lock kept");
    sweep(8'h22);
    cfg_write(2'b10, "R11 lock cleared");
    sweep(8'h33);
    cfg_write(2'b11, "R4 write 1 ignored");
    acc(16'hFC05, 1'b1, 8'hC3);
    acc(16'hFC05, 1'b0, 8'h00);
    cfg_write(2'b00, "R5 clear again");
    cfg_write(2'b00, "R5 clear repeated");
    for (int i = 0; i < 1024; i++) acc(16'hFC00 + 16'(i), 1'b1, 8'(i * 7) ^ 8'h96);
    for (int i = 0; i < 1024; i++) acc(16'hFC00 + 16'(i), 1'b0, 8'h00);
    sweep(8'h44);
    cfg_write(2'b01, "R4 lock stays clear");
    sweep(8'h55);
    do_reset();
    acc(16'hFC05, 1'b0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule